// File: doc/BRIEF.md
# Node-Resident Five-Output Packet Switch

This block is the packet switch inside one compute node of a cluster built from two racks of four nodes. Packets reach it from five places: the node's own traffic source, three links to the other nodes of the same rack, and one link to the matching node of the other rack. Each packet leaves on one of five outputs: one of the three same-rack links, the link to the other rack, or the local delivery port. The first word of every packet carries a 3-bit destination identifier. Bit 2 of that identifier names the rack and bits 1:0 name the node within the rack.

The traffic-source input and the cross-rack input each hold four packet queues, kept apart by where the packet goes next. The three same-rack inputs carry only traffic for this node, so they have no queue and hand their words straight to the delivery port. That gives eleven sources feeding five outputs. Every output has its own matrix arbiter, which takes a fresh and fair decision on each cycle. Once an output is granted, it stays with the winning source until that packet's last word has gone. A packet bound for the other rack crosses on the cross-rack link, and the receiving node forwards it within its rack. Any path therefore takes at most two hops.

Flow control works in whole packet slots, so no packet is ever dropped. The upstream side of a queued input spends one credit for each packet it sends, and the switch returns that credit when the packet's last word leaves the queue. Each output keeps a count of the free slots downstream and starts a packet only while that count is non-zero. The links are plain word streams in which each word carries a last-word flag. The same-rack inputs use a valid/ready handshake.

Top module: `node_switch`

## Requirements
- R1: After reset every output valid, every credit-return pulse and every same-rack ready is low.
- R2: A packet from the traffic source addressed to another node of this rack leaves on same-rack output k. Here k is the destination's in-rack index, less one if that index is above this node's own index, and the same value is the queue number, 0 to 2. A packet for the other rack, whatever its in-rack index, uses queue 3 and leaves on output 3. The source never addresses this node.
- R3: A packet on the cross-rack input addressed to this node uses queue 3 and leaves on the delivery port, output 4. One addressed to another node of this rack uses queue k, worked out as in R2, and leaves on same-rack output k. Packets on this input always carry this rack's bit.
- R4: Words on same-rack input j (0 to 2) are taken only while ready is high. They always leave on the delivery port, with their content unchanged.
- R5: A queued input is delayed by 4 receive stages, 5 switching stages and 4 transmit stages. With no contention, the first word therefore appears 13 clock edges after the edge that samples it. A same-rack input skips the receive stages and the queue, so its first word appears 9 edges after the edge that takes it.
- R6: When several sources want the same free output in one cycle, the arbiter grants the one that has waited longest since its last grant. The lowest-numbered source wins when no grant has yet been made.
- R7: Once an output starts a packet, no word from any other source appears on it until that packet's last word has passed.
- R8: When the last word of a packet leaves queue v of a queued input, that input raises bit v of its credit-return output for exactly one cycle.
- R9: An output holds OUT_CREDITS packet slots after reset. Each started packet takes one slot and each pulse on its credit input gives one back. No packet starts while the count is zero.
- R10: A queue holds VC_PKTS packets of up to PKT_WORDS words. Packets that wait in a queue are delivered complete and in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Traffic-source word valid |
| src_data | input | 32 | Traffic-source word; bits 2:0 of the first word are the destination |
| src_last | input | 1 | Traffic-source last word of packet |
| src_credit | output | 4 | Per-queue slot return to the traffic source |
| xr_valid | input | 1 | Cross-rack input word valid |
| xr_data | input | 32 | Cross-rack input word |
| xr_last | input | 1 | Cross-rack input last word |
| xr_credit | output | 4 | Per-queue slot return on the cross-rack link |
| lr_valid | input | 3 | Same-rack input word valid, one bit per link |
| lr_data | input | 3x32 | Same-rack input words |
| lr_last | input | 3 | Same-rack input last word flags |
| lr_ready | output | 3 | Same-rack input word accepted |
| out_valid | output | 5 | Output word valid (0..2 same-rack, 3 cross-rack, 4 delivery) |
| out_data | output | 5x32 | Output words |
| out_last | output | 5 | Output last word flags |
| out_credit | input | 5 | Downstream slot return, one pulse per freed packet slot |

## Verification
The hardest case to reach from the ports is a packet held in a queue while its output has no downstream slots left. Only that case shows that credits are returned as packets drain, rather than when they arrive. The bench withholds the output's credit pulses and sends more packets to one queue than the output has slots. While the extra packets wait, it checks the output and the credit-return pulses, and then it releases the slots and checks that delivery resumes in order. A second case that is hard to reach is arbitration fairness. Two same-rack links both keep a packet pending back to back on the same delivery port, which exposes the order in which the matrix arbiter grants them.

// File: rtl/router_pkg.sv
package router_pkg;
    // Word width of every link in the switch.
    localparam int WORD_W    = 32;
    localparam int N_OUT     = 5;
    localparam int N_IN      = 11;
    localparam int N_VC      = 4;
    localparam int N_LR      = 3;
    localparam int OUT_XR    = 3;
    localparam int OUT_DELIV = 4;
    localparam int IN_SRC0   = 0;
    localparam int IN_XR0    = 4;
    localparam int IN_LR0    = 8;
    localparam int SEL_W     = $clog2(N_IN);

    typedef struct packed {
        logic              last;
        logic [WORD_W-1:0] data;
    } flit_t;

    // Slot of a same-rack peer, counting this node out.
    function automatic logic [1:0] peer_slot(input logic [1:0] mine, input logic [1:0] dst);
        return (dst < mine) ? dst : dst - 2'd1;
    endfunction

    // Queue used by a packet with the given destination.
    function automatic logic [1:0] queue_of(input logic from_xr, input logic [2:0] me,
                                            input logic [2:0] dst);
        if (from_xr)
            return (dst[1:0] == me[1:0]) ? 2'd3 : peer_slot(me[1:0], dst[1:0]);
        return (dst[2] != me[2]) ? 2'd3 : peer_slot(me[1:0], dst[1:0]);
    endfunction

    // Output reached by each of the eleven switch sources.
    function automatic int route_of(input int src);
        if (src < IN_XR0) return src;
        if (src < IN_LR0) return (src - IN_XR0 < 3) ? src - IN_XR0 : OUT_DELIV;
        return OUT_DELIV;
    endfunction
endpackage

// File: rtl/pipe_delay.sv
module pipe_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic [DEPTH-1:0]        v_q;
    logic [DEPTH-1:0][W-1:0] d_q;

    always_ff @(posedge clk) begin
        if (rst) v_q <= '0;
        else begin
            v_q[0] <= in_valid;
            for (int k = 1; k < DEPTH; k++) v_q[k] <= v_q[k-1];
        end
        d_q[0] <= in_data;
        for (int k = 1; k < DEPTH; k++) d_q[k] <= d_q[k-1];
    end

    assign out_valid = v_q[DEPTH-1];
    assign out_data  = d_q[DEPTH-1];
endmodule

// File: rtl/vc_input.sv
module vc_input
    import router_pkg::*;
#(
    parameter bit         FROM_XR  = 1'b0,
    parameter logic [2:0] ME       = 3'd1,
    parameter int         RX_DLY   = 3,
    parameter int         VC_WORDS = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  flit_t                 in_flit,
    input  logic [N_VC-1:0]       pop,
    output logic [N_VC-1:0]       head_valid,
    output flit_t [N_VC-1:0]      head,
    output logic [N_VC-1:0]       credit_ret
);
    localparam int AW = $clog2(VC_WORDS);
    localparam int FW = $bits(flit_t);

    logic          rx_v;
    logic [FW-1:0] rx_d;
    flit_t         rx_f;
    logic          mid_q;
    logic [1:0]    cur_q, wq;
    logic [N_VC-1:0] push;

    pipe_delay #(.W(FW), .DEPTH(RX_DLY)) i_rx (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_flit),
        .out_valid(rx_v), .out_data(rx_d)
    );
    assign rx_f = flit_t'(rx_d);
    assign wq   = mid_q ? cur_q : queue_of(FROM_XR, ME, rx_f.data[2:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_q <= 1'b0;
            cur_q <= '0;
        end else if (rx_v) begin
            mid_q <= !rx_f.last;
            cur_q <= wq;
        end
    end

    for (genvar v = 0; v < N_VC; v++) begin : g_q
        flit_t         mem [VC_WORDS];
        logic [AW-1:0] wp, rp;
        logic [AW:0]   cnt;

        assign push[v]       = rx_v && (wq == 2'(v));
        assign head_valid[v] = (cnt != '0);
        assign head[v]       = mem[rp];

        always_ff @(posedge clk) begin
            if (rst) begin
                wp <= '0; rp <= '0; cnt <= '0; credit_ret[v] <= 1'b0;
            end else begin
                if (push[v]) begin
                    mem[wp] <= rx_f;
                    wp <= (wp == AW'(VC_WORDS-1)) ? '0 : wp + 1'b1;
                end
                if (pop[v]) rp <= (rp == AW'(VC_WORDS-1)) ? '0 : rp + 1'b1;
                cnt <= cnt + (AW+1)'(push[v]) - (AW+1)'(pop[v]);
                credit_ret[v] <= pop[v] && head[v].last;
            end
        end

        // R10: credits keep a queue from ever being written while full
        assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
            push[v] |-> (cnt < (AW+1)'(VC_WORDS)));
        // R8: the switch only drains a queue that holds a word
        assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (rst)
            pop[v] |-> head_valid[v]);
    end

    if (FROM_XR) begin : g_chk_xr
        // R3: cross-rack arrivals always belong to this rack
        assert_xr_rack_R3: assert property (@(posedge clk) disable iff (rst)
            (rx_v && !mid_q) |-> (rx_f.data[2] == ME[2]));
    end else begin : g_chk_src
        // R2: the local source never addresses its own node
        assert_src_not_self_R2: assert property (@(posedge clk) disable iff (rst)
            (rx_v && !mid_q) |-> (rx_f.data[2:0] != ME));
    end
endmodule

// File: rtl/matrix_arb.sv
module matrix_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         take,
    output logic [N-1:0] gnt
);
    // wins_q[i][j] set: source i is preferred over source j
    logic [N-1:0][N-1:0] wins_q;

    always_comb begin
        gnt = req;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (j != i && req[j] && wins_q[j][i]) gnt[i] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    wins_q[i][j] <= (i < j);
        end else if (take) begin
            for (int i = 0; i < N; i++)
                if (gnt[i])
                    for (int j = 0; j < N; j++)
                        if (j != i) begin
                            wins_q[i][j] <= 1'b0;
                            wins_q[j][i] <= 1'b1;
                        end
        end
    end

    // R6: at most one winner per cycle
    assert_one_grant_R6: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
    // R6: a winner that is granted again must have lost priority in between
    assert_winner_demoted_R6: assert property (@(posedge clk) disable iff (rst)
        (take && $onehot(gnt) && $countones(req) > 1) |=> !(take && gnt == $past(gnt) && req == $past(req)));
endmodule

// File: rtl/node_switch.sv
module node_switch
    import router_pkg::*;
#(
    parameter logic [2:0] MY_ID       = 3'b001,
    parameter int         RX_LAT      = 4,
    parameter int         SW_LAT      = 5,
    parameter int         TX_LAT      = 4,
    parameter int         PKT_WORDS   = 4,
    parameter int         VC_PKTS     = 4,
    parameter int         OUT_CREDITS = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         src_valid,
    input  logic [WORD_W-1:0]            src_data,
    input  logic                         src_last,
    output logic [N_VC-1:0]              src_credit,
    input  logic                         xr_valid,
    input  logic [WORD_W-1:0]            xr_data,
    input  logic                         xr_last,
    output logic [N_VC-1:0]              xr_credit,
    input  logic [N_LR-1:0]              lr_valid,
    input  logic [N_LR-1:0][WORD_W-1:0]  lr_data,
    input  logic [N_LR-1:0]              lr_last,
    output logic [N_LR-1:0]              lr_ready,
    output logic [N_OUT-1:0]             out_valid,
    output logic [N_OUT-1:0][WORD_W-1:0] out_data,
    output logic [N_OUT-1:0]             out_last,
    input  logic [N_OUT-1:0]             out_credit
);
    localparam int VC_WORDS = PKT_WORDS * VC_PKTS;
    localparam int CW       = $clog2(OUT_CREDITS + 1);
    localparam int OUT_DLY  = SW_LAT - 1 + TX_LAT;
    localparam int FW       = $bits(flit_t);

    logic  [N_IN-1:0]             src_v, taken;
    flit_t [N_IN-1:0]             src_f;
    logic  [N_VC-1:0]             s_hv, x_hv;
    flit_t [N_VC-1:0]             s_hd, x_hd;

    logic  [N_OUT-1:0][N_IN-1:0]  req, gnt;
    logic  [N_OUT-1:0][SEL_W-1:0] sel, owner;
    logic  [N_OUT-1:0][CW-1:0]    slots;
    logic  [N_OUT-1:0]            lock, take, send, xv;
    flit_t [N_OUT-1:0]            sf, xf;

    vc_input #(.FROM_XR(1'b0), .ME(MY_ID), .RX_DLY(RX_LAT-1), .VC_WORDS(VC_WORDS)) i_src (
        .clk(clk), .rst(rst), .in_valid(src_valid), .in_flit({src_last, src_data}),
        .pop(taken[IN_XR0-1:IN_SRC0]), .head_valid(s_hv), .head(s_hd), .credit_ret(src_credit)
    );
    vc_input #(.FROM_XR(1'b1), .ME(MY_ID), .RX_DLY(RX_LAT-1), .VC_WORDS(VC_WORDS)) i_xr (
        .clk(clk), .rst(rst), .in_valid(xr_valid), .in_flit({xr_last, xr_data}),
        .pop(taken[IN_LR0-1:IN_XR0]), .head_valid(x_hv), .head(x_hd), .credit_ret(xr_credit)
    );

    // Gather the eleven switch sources.
    for (genvar i = 0; i < N_IN; i++) begin : g_src
        localparam int RO = route_of(i);
        if (i < IN_XR0) begin : g_s
            assign src_v[i] = s_hv[i];
            assign src_f[i] = s_hd[i];
        end else if (i < IN_LR0) begin : g_x
            assign src_v[i] = x_hv[i-IN_XR0];
            assign src_f[i] = x_hd[i-IN_XR0];
        end else begin : g_l
            assign src_v[i] = lr_valid[i-IN_LR0];
            assign src_f[i] = {lr_last[i-IN_LR0], lr_data[i-IN_LR0]};
        end
        assign taken[i] = send[RO] && (sel[RO] == SEL_W'(i));
    end
    assign lr_ready = taken[N_IN-1:IN_LR0];

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic          ov;
        logic [FW-1:0] od;

        for (genvar i = 0; i < N_IN; i++) begin : g_req
            if (route_of(i) == o) begin : g_on
                assign req[o][i] = src_v[i] && !lock[o] && (slots[o] != '0);
            end else begin : g_off
                assign req[o][i] = 1'b0;
            end
        end

        matrix_arb #(.N(N_IN)) i_arb (
            .clk(clk), .rst(rst), .req(req[o]), .take(take[o]), .gnt(gnt[o])
        );

        always_comb begin
            sel[o] = owner[o];
            if (!lock[o])
                for (int i = 0; i < N_IN; i++)
                    if (gnt[o][i]) sel[o] = SEL_W'(i);
        end

        assign take[o] = !lock[o] && (gnt[o] != '0);
        assign send[o] = (lock[o] || take[o]) && src_v[sel[o]];
        assign sf[o]   = src_f[sel[o]];

        always_ff @(posedge clk) begin
            if (rst) begin
                lock[o]  <= 1'b0;
                owner[o] <= '0;
                slots[o] <= CW'(OUT_CREDITS);
                xv[o]    <= 1'b0;
            end else begin
                if (send[o]) begin
                    lock[o]  <= !sf[o].last;
                    owner[o] <= sel[o];
                end
                slots[o] <= slots[o] - CW'(take[o]) + CW'(out_credit[o]);
                xv[o]    <= send[o];
            end
            xf[o] <= sf[o];
        end

        pipe_delay #(.W(FW), .DEPTH(OUT_DLY)) i_tx (
            .clk(clk), .rst(rst), .in_valid(xv[o]), .in_data(xf[o]),
            .out_valid(ov), .out_data(od)
        );
        assign out_valid[o] = ov;
        assign {out_last[o], out_data[o]} = od;

        // R7: a packet in flight keeps its output until the last word
        assert_hold_grant_R7: assert property (@(posedge clk) disable iff (rst)
            (send[o] && !sf[o].last) |=> (lock[o] && owner[o] == $past(sel[o])));
        // R9: slot count stays within what downstream can hold
        assert_slot_cap_R9: assert property (@(posedge clk) disable iff (rst)
            slots[o] <= CW'(OUT_CREDITS));
        // R9: a packet never starts when the previous cycle left no slot and none returned
        assert_no_slot_start_R9: assert property (@(posedge clk) disable iff (rst)
            (slots[o] == '0 && !out_credit[o]) |=> !take[o]);
    end

    for (genvar k = 0; k < N_LR; k++) begin : g_lr_chk
        // R4: a same-rack word offered and not taken is still offered next cycle
        assert_lr_hold_R4: assert property (@(posedge clk) disable iff (rst)
            (lr_valid[k] && !lr_ready[k]) |=> lr_valid[k]);
    end
endmodule

// File: tb/test_node_switch.sv
module test_node_switch;
    import router_pkg::*;

    localparam logic [2:0] ME  = 3'b001;
    localparam int PW  = 4;
    localparam int VCP = 4;
    localparam int OC  = 2;

    logic clk = 1'b0, rst = 1'b1;
    always #10 clk = ~clk;

    logic src_valid = 0, src_last = 0, xr_valid = 0, xr_last = 0;
    logic [WORD_W-1:0] src_data = '0, xr_data = '0;
    logic [N_VC-1:0] src_credit, xr_credit;
    logic [N_LR-1:0] lr_valid = '0, lr_last = '0, lr_ready;
    logic [N_LR-1:0][WORD_W-1:0] lr_data = '0;
    logic [N_OUT-1:0] out_valid, out_last, out_credit = '0;
    logic [N_OUT-1:0][WORD_W-1:0] out_data;

    node_switch #(.MY_ID(ME), .PKT_WORDS(PW), .VC_PKTS(VCP), .OUT_CREDITS(OC)) i_node_switch (
        .clk(clk), .rst(rst),
        .src_valid(src_valid), .src_data(src_data), .src_last(src_last), .src_credit(src_credit),
        .xr_valid(xr_valid), .xr_data(xr_data), .xr_last(xr_last), .xr_credit(xr_credit),
        .lr_valid(lr_valid), .lr_data(lr_data), .lr_last(lr_last), .lr_ready(lr_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_credit(out_credit)
    );

    int ntests = 0, nfail = 0, cyc = 0;
    bit done = 0, auto_ret = 1;
    logic [WORD_W:0] oq [N_OUT][$];
    int ocyc [N_OUT][$];
    int tails [N_OUT], ret [N_OUT];
    int scred [N_VC], xcred [N_VC], s_ret [N_VC];
    int last_t0;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        for (int v = 0; v < N_VC; v++) begin scred[v] = VCP; xcred[v] = VCP; s_ret[v] = 0; end
        for (int o = 0; o < N_OUT; o++) begin tails[o] = 0; ret[o] = 0; end
    end

    // Output monitor, upstream credit tracking and downstream slot return.
    always @(negedge clk) if (!rst) begin
        for (int o = 0; o < N_OUT; o++) begin
            if (out_valid[o]) begin
                oq[o].push_back({out_last[o], out_data[o]});
                ocyc[o].push_back(cyc);
                if (out_last[o]) tails[o]++;
            end
            out_credit[o] = auto_ret && (tails[o] > ret[o]);
            if (out_credit[o]) ret[o]++;
        end
        for (int v = 0; v < N_VC; v++) begin
            if (src_credit[v]) begin scred[v]++; s_ret[v]++; end
            if (xr_credit[v]) xcred[v]++;
        end
    end

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] wd(input int tag, input int k, input logic [2:0] dst);
        return WORD_W'((tag << 8) | (k << 3) | dst);
    endfunction

    // Queue number per R2/R3, written from the requirement text.
    function automatic int exp_q(input bit from_xr, input logic [2:0] dst);
        int slot = (dst[1:0] > ME[1:0]) ? dst[1:0] - 1 : dst[1:0];
        if (from_xr) return (dst[1:0] == ME[1:0]) ? 3 : slot;
        return (dst[2] != ME[2]) ? 3 : slot;
    endfunction

    task automatic clear_mon();
        for (int o = 0; o < N_OUT; o++) begin oq[o].delete(); ocyc[o].delete(); end
    endtask

    task automatic send_q(input bit from_xr, input logic [2:0] dst, input int tag, input int n);
        int q = exp_q(from_xr, dst);
        while ((from_xr ? xcred[q] : scred[q]) == 0) @(negedge clk);
        if (from_xr) xcred[q]--; else scred[q]--;
        for (int k = 0; k < n; k++) begin
            if (k == 0) last_t0 = cyc;
            if (from_xr) begin xr_valid = 1; xr_data = wd(tag, k, dst); xr_last = (k == n-1); end
            else begin src_valid = 1; src_data = wd(tag, k, dst); src_last = (k == n-1); end
            @(negedge clk);
        end
        src_valid = 0; xr_valid = 0; src_last = 0; xr_last = 0;
    endtask

    task automatic send_lr(input int j, input logic [2:0] dst, input int tag, input int n);
        for (int k = 0; k < n; k++) begin
            bit got;
            lr_valid[j] = 1; lr_data[j] = wd(tag, k, dst); lr_last[j] = (k == n-1);
            forever begin
                #1 got = lr_ready[j];
                if (got && k == 0) last_t0 = cyc;
                @(negedge clk);
                if (got) break;
            end
        end
        lr_valid[j] = 0; lr_last[j] = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(out_valid == '0, "R1 out_valid", out_valid, 0);
        chk(src_credit == '0 && xr_credit == '0, "R1 credit pulses", {src_credit, xr_credit}, 0);
        chk(lr_ready == '0, "R1 lr_ready", lr_ready, 0);
    endtask

    task automatic t_src_route();
        clear_mon();
        send_q(0, 3'd0, 1, PW);
        send_q(0, 3'd3, 2, PW);
        send_q(0, 3'd6, 3, PW);
        send_q(0, 3'd5, 4, PW);
        wait_cyc(40);
        chk(oq[0].size() == PW && oq[0][0] == {1'b0, wd(1, 0, 0)}, "R2 dest0 on out0", oq[0].size(), PW);
        chk(oq[2].size() == PW && oq[2][PW-1] == {1'b1, wd(2, PW-1, 3)}, "R2 dest3 on out2",
            oq[2].size(), PW);
        chk(oq[3].size() == 2*PW && oq[3][0][WORD_W-1:8] == 3 && oq[3][PW][WORD_W-1:8] == 4,
            "R2 other rack on out3", oq[3].size(), 2*PW);
        chk(oq[1].size() == 0 && oq[4].size() == 0, "R2 no stray output", oq[1].size() + oq[4].size(), 0);
    endtask

    task automatic t_latency();
        clear_mon();
        send_q(0, 3'd2, 20, 1);
        wait_cyc(20);
        chk(ocyc[1].size() == 1 && ocyc[1][0] == last_t0 + 13, "R5 queued path latency",
            ocyc[1].size() ? ocyc[1][0] - last_t0 : -1, 13);
    endtask

    task automatic t_xr_route();
        clear_mon();
        send_q(1, 3'd1, 5, PW);
        send_q(1, 3'd2, 6, PW);
        wait_cyc(30);
        chk(oq[4].size() == PW && oq[4][0][WORD_W-1:8] == 5, "R3 self-addressed to delivery",
            oq[4].size(), PW);
        chk(oq[1].size() == PW && oq[1][PW-1] == {1'b1, wd(6, PW-1, 2)}, "R3 relay to out1",
            oq[1].size(), PW);
        chk(xcred[3] == VCP && xcred[1] == VCP, "R8 cross-rack credits returned", xcred[3], VCP);
    endtask

    task automatic t_lr();
        clear_mon();
        send_lr(2, 3'd1, 7, 2);
        wait_cyc(15);
        chk(oq[4].size() == 2 && oq[4][1] == {1'b1, wd(7, 1, 1)}, "R4 same-rack words delivered",
            oq[4].size(), 2);
        chk(ocyc[4].size() > 0 && ocyc[4][0] == last_t0 + 9, "R5 same-rack latency",
            ocyc[4].size() ? ocyc[4][0] - last_t0 : -1, 9);
    endtask

    task automatic t_arb();
        int exp_tag [4] = '{8, 10, 9, 11};
        bit contig = 1;
        clear_mon();
        fork
            begin send_lr(0, 3'd1, 8, 3); send_lr(0, 3'd1, 9, 3); end
            begin send_lr(1, 3'd1, 10, 3); send_lr(1, 3'd1, 11, 3); end
        join
        wait_cyc(30);
        chk(oq[4].size() == 12, "R6 all contended words out", oq[4].size(), 12);
        for (int p = 0; p < 4; p++) begin
            int t = (oq[4].size() > 3*p) ? int'(oq[4][3*p][WORD_W-1:8]) : -1;
            chk(t == exp_tag[p], "R6 grant order", t, exp_tag[p]);
            for (int k = 0; k < 3; k++)
                if (oq[4].size() > 3*p+k && oq[4][3*p+k][WORD_W-1:8] != exp_tag[p]) contig = 0;
        end
        chk(contig, "R7 packets not interleaved", contig, 1);
    endtask

    task automatic t_credit();
        int base = s_ret[0];
        bit inorder = 1;
        clear_mon();
        auto_ret = 0;
        wait_cyc(3);
        for (int p = 0; p < VCP; p++) send_q(0, 3'd0, 30 + p, PW);
        wait_cyc(60);
        chk(oq[0].size() == OC*PW, "R9 stops at slot limit", oq[0].size(), OC*PW);
        chk(s_ret[0] - base == OC, "R8 one return per drained packet", s_ret[0] - base, OC);
        auto_ret = 1;
        wait_cyc(80);
        chk(oq[0].size() == VCP*PW, "R10 held packets delivered", oq[0].size(), VCP*PW);
        for (int i = 0; i < oq[0].size(); i++)
            if (oq[0][i] != {i % PW == PW-1, wd(30 + i / PW, i % PW, 0)}) inorder = 0;
        chk(inorder, "R10 arrival order kept", inorder, 1);
        chk(s_ret[0] - base == VCP, "R8 all queue slots returned", s_ret[0] - base, VCP);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_src_route();
        t_latency();
        t_xr_route();
        t_lr();
        t_arb();
        t_credit();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            ntests++; nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end
endmodule